// File: doc/BRIEF.md
# Masked Input Port Interrupt

A four-bit general input port that lets software read the pin levels and get an interrupt when an enabled pin goes high. Each pin is synchronised to the clock and then filtered by a noise rejector. The rejector accepts a new level only after that level has stayed unchanged for a set number of clocks. Software reads the filtered levels as one word.

Each pin has its own enable bit. All four pins share one event flag. The flag is set on the rising edge of (filtered level AND enable) for any pin, so it also sets when software enables a pin that is already high. The interrupt request output follows the flag. The flag stays set, and the request stays asserted, until software reads the flag register. That read clears the flag. If a new event arrives in the same cycle as that read, the flag stays set.

The bus is a single-cycle strobe interface. A read returns data combinationally in the cycle its strobe is high. A write takes effect at the next clock edge.

Top module: `kport_irq`

## Requirements
- R1: After reset the enable register reads 0000 and the flag reads 0. The request is low, and with the pins low the level register reads 0000.
- R2: A read at address 0 returns the filtered pin levels, with bit i holding pin i. A new pin level appears there no more than SYNC_STAGES+STABLE_CYCLES+1 clocks after it is applied.
- R3: The noise rejector ignores a pin pulse that lasts fewer than STABLE_CYCLES clocks. Such a pulse changes neither the level register nor the flag, even when the pin is enabled.
- R4: The enable register is at address 1. Writing 1 to bit i enables pin i and writing 0 masks it. The written value reads back. Writes to any other address have no effect.
- R5: When an enabled pin's filtered level rises from 0 to 1, the flag is set. A rising level on a masked pin does not set the flag.
- R6: If software writes 1 to a pin's enable bit while that pin's filtered level is already 1, the flag is set.
- R7: A pin held steadily high sets the flag only once. After the flag is cleared by a read, it stays 0 while the pin stays high.
- R8: The flag is read at address 2, bit 0, and bits 3..1 read 0. Reading address 2 clears the flag after that read.
- R9: If a new event occurs in the same cycle as a read of address 2, the flag is 1 after that cycle. The read itself returns the flag's value from before that cycle.
- R10: The request output is high exactly while the flag is set. Without a flag read it stays high for as long as the flag holds.
- R11: All four pins share the one flag. An event from any enabled pin sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | WIDTH | Raw input pins |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 level, 1 enable, 2 flag |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data; 0 when no read strobe |
| irq | output | 1 | Interrupt request |

## Verification
A flag-clearing read and a new event can fall in the same clock cycle. To make this happen at an exact cycle, the bench re-arms an already-high pin: it writes its enable bit to 0, then to 1, and reads address 2 in the very next cycle. That is the cycle in which the rise of level AND enable is seen. This is done once with the flag clear and once with it already set. Each time, the read must return the old flag, the following read must return 1, and a third read must return 0.

// File: rtl/kport_irq.sv
module kport_irq #(
  parameter int WIDTH         = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic             irq
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam int SW = SYNC_STAGES * WIDTH;

  logic [SW-1:0]    sync_sh;
  logic [WIDTH-1:0] syn, filt, mask, armed, armed_q;
  logic [CW-1:0]    cnt [WIDTH];
  logic             flag, rise, rd_flag, wr_mask;

  assign syn     = sync_sh[SW-1 -: WIDTH];
  assign armed   = filt & mask;
  assign rise    = |(armed & ~armed_q);
  assign rd_flag = bus_rd && bus_addr == 2'd2;
  assign wr_mask = bus_wr && bus_addr == 2'd1;
  assign irq     = flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= {sync_sh[SW-WIDTH-1:0], pin_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt <= '0;
      for (int i = 0; i < WIDTH; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < WIDTH; i++) begin
        if (syn[i] == filt[i]) cnt[i] <= '0;
        else if (cnt[i] == CW'(STABLE_CYCLES - 1)) begin
          filt[i] <= syn[i];
          cnt[i]  <= '0;
        end else cnt[i] <= cnt[i] + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask    <= '0;
      armed_q <= '0;
      flag    <= 1'b0;
    end else begin
      if (wr_mask) mask <= bus_wdata;
      armed_q <= armed;
      if (rise)         flag <= 1'b1;
      else if (rd_flag) flag <= 1'b0;
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd)
      case (bus_addr)
        2'd0:    bus_rdata = filt;
        2'd1:    bus_rdata = mask;
        2'd2:    bus_rdata = {{(WIDTH-1){1'b0}}, flag};
        default: bus_rdata = '0;
      endcase
  end

  p_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> $past(syn) == filt);
  p_mask_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask == $past(bus_wdata));
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> flag);
  p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(|(filt & mask)));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag && !rise) |=> !irq);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_flag) |=> irq);
endmodule

// File: tb/sim_kport_irq.sv
module sim_kport_irq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] pin_in = '0, bus_wdata = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [3:0] bus_rdata;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] exp_q [$];
  string      tag_q [$];

  kport_irq u0 (.*);

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [3:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #5;
    if (bus_rd) begin
      if (exp_q.size() == 0) check("scoreboard", 4'hF, 4'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    check("watchdog", 4'h1, 4'h0);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    rd(2'd0, 4'h0, "R1 level");
    rd(2'd1, 4'h0, "R1 enable");
    check("R1 irq", {3'b0, irq}, 4'h0);
    rd(2'd2, 4'h0, "R1 flag");

    pin_in = 4'b1010; idle(8);
    rd(2'd0, 4'b1010, "R2 level 1010");
    rd(2'd2, 4'h0, "R5 masked rise no flag");
    pin_in = 4'b0101; idle(8);
    rd(2'd0, 4'b0101, "R2 level 0101");
    pin_in = 4'b0000; idle(8);
    rd(2'd2, 4'h0, "R5 masked no flag");

    wr(2'd1, 4'b0011);
    wr(2'd0, 4'b1111);
    wr(2'd2, 4'b1111);
    rd(2'd1, 4'b0011, "R4 enable readback");
    rd(2'd0, 4'h0, "R4 level unaffected by write");
    rd(2'd2, 4'h0, "R4 flag unaffected by write");

    pin_in[0] = 1'b1; @(negedge clk); pin_in[0] = 1'b0;
    idle(8);
    rd(2'd0, 4'h0, "R3 glitch level");
    check("R3 glitch irq", {3'b0, irq}, 4'h0);
    rd(2'd2, 4'h0, "R3 glitch flag");

    pin_in[1] = 1'b1; idle(8);
    check("R10 irq high", {3'b0, irq}, 4'h1);
    idle(10);
    check("R10 irq held", {3'b0, irq}, 4'h1);
    rd(2'd2, 4'h1, "R8 flag read 1");
    check("R10 irq low after read", {3'b0, irq}, 4'h0);
    rd(2'd2, 4'h0, "R8 flag cleared");
    idle(6);
    rd(2'd2, 4'h0, "R7 steady high no reset");

    pin_in[3] = 1'b1; idle(8);
    rd(2'd2, 4'h0, "R5 masked bit3");
    wr(2'd1, 4'b1011);
    idle(2);
    rd(2'd2, 4'h1, "R6 enable while high");
    rd(2'd2, 4'h0, "R8 clear after R6");
    pin_in[0] = 1'b1; idle(8);
    check("R11 bit0 irq", {3'b0, irq}, 4'h1);
    rd(2'd2, 4'h1, "R11 bit0 flag");

    wr(2'd1, 4'b0000);
    wr(2'd1, 4'b0001);
    rd(2'd2, 4'h0, "R9 read in set cycle old 0");
    rd(2'd2, 4'h1, "R9 flag kept");
    rd(2'd2, 4'h0, "R9 then cleared");
    wr(2'd1, 4'b0010);
    idle(2);
    check("R9 prep irq", {3'b0, irq}, 4'h1);
    wr(2'd1, 4'b0000);
    wr(2'd1, 4'b0010);
    rd(2'd2, 4'h1, "R9 read in set cycle old 1");
    rd(2'd2, 4'h1, "R9 flag kept 2");
    rd(2'd2, 4'h0, "R9 then cleared 2");

    idle(2);
    check("scoreboard empty", 4'(exp_q.size()), 4'h0);
    finish_run();
  end
endmodule